// File: doc/BRIEF.md
# I/O Port Wait-State Generator

This block drives the READY input of a small processor that uses a multiplexed address/data bus. When the processor reads or writes one particular I/O port, the block holds READY low for a fixed number of clock cycles. Logic behind that port, such as auto-stepping address counters and an output data path, uses these cycles to settle before the transfer completes. Memory cycles, including opcode fetches, and I/O cycles to any other port never produce a wait.

Every flip-flop is clocked by the processor clock, with no gating. The block has no reset pin. An address-latch-enable pulse seen on a rising edge returns the logic to the idle, ready state, so the first opcode fetch after power-up puts it in a known state. A flag fed back from the block's own state allows only one wait sequence per bus cycle. A parameter sets the number of waits: two by default, and one as the reduced option.

Top module: `io_wait_gen`

## Requirements
- R1: On any rising edge where `ale` is 1, `ready` becomes 1 after that edge, whatever the other inputs are. This includes a qualifying strobe sampled at the same edge.
- R2: A qualifying access is a rising edge with `ale`=0, `io_cycle`=1 (1 means I/O, 0 means memory), `port_sel`=1, and `rd_n`=0 or `wr_n`=0 (both strobes are active low). After the first such edge in a bus cycle, `ready` is 0.
- R3: After a qualifying edge, `ready` stays 0 for exactly `WAIT_STATES` clock cycles and then returns to 1. This holds even if the strobe is released earlier.
- R4: Cycles with `io_cycle`=0 never drive `ready` to 0, even when `port_sel` is 1.
- R5: I/O cycles with `port_sel`=0 never drive `ready` to 0.
- R6: At most one wait sequence runs between two `ale` pulses. A strobe held after the waits end does not start another, and neither does a second strobe pulse.
- R7: An `ale` pulse sampled while a wait sequence is running ends it, and `ready` is 1 after that edge.
- R8: A read strobe and a write strobe produce the same wait sequence.
- R9: With `WAIT_STATES`=1, a qualifying access produces exactly one low cycle on `ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; all state changes on its rising edge |
| ale | input | 1 | Address latch enable; 1 starts a bus cycle and clears the block |
| io_cycle | input | 1 | Bus cycle type: 1 = I/O, 0 = memory |
| port_sel | input | 1 | 1 when the decoded I/O address is the designated port |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ready | output | 1 | Registered READY to the processor; 0 requests a wait |

## Verification
The clear from `ale` and the start from a qualifying strobe can both be sampled at the same rising edge. The clear can also arrive while a wait sequence is still counting. The bench drives both cases: `ale` held high together with an active strobe to the designated port, and `ale` raised one cycle into a wait. The bench expects the clear to win in both, with `ready` high straight after that edge and a fresh wait starting only at a later edge with `ale` low. A behavioural model with a countdown and a used flag judges every cycle for both the two-wait and the one-wait instance, and per-bus-cycle tallies of low cycles confirm the totals.

// File: rtl/iowg_pkg.sv
package iowg_pkg;

    typedef struct packed {
        logic ale;
        logic io_cycle;
        logic port_sel;
        logic rd_act;
        logic wr_act;
    } bus_sample_t;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_START = 2'd2
    } wait_act_e;

    function automatic logic hits_target(input bus_sample_t s);
        return s.io_cycle && s.port_sel && (s.rd_act || s.wr_act);
    endfunction

endpackage

// File: rtl/iowg_access_gate.sv
module iowg_access_gate
    import iowg_pkg::*;
(
    input  logic        clk,
    input  bus_sample_t bus,
    output wait_act_e   act
);

    // Set once a sequence has started; cleared only by the bus-cycle start.
    logic served;

    always_comb begin
        if (bus.ale) begin
            act = ACT_CLEAR;
        end else if (hits_target(bus) && !served) begin
            act = ACT_START;
        end else begin
            act = ACT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (act == ACT_CLEAR) begin
            served <= 1'b0;
        end else if (act == ACT_START) begin
            served <= 1'b1;
        end
    end

endmodule

// File: rtl/iowg_wait_chain.sv
module iowg_wait_chain
    import iowg_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic      clk,
    input  wait_act_e act,
    output logic      ready
);

    localparam int TAIL_LEN = WAIT_STATES - 1;

    logic start;
    logic tail_busy;

    assign start = (act == ACT_START);

    generate
        if (TAIL_LEN > 0) begin : g_tail
            logic [TAIL_LEN-1:0] tail;
            logic [TAIL_LEN-1:0] tail_next;

            always_comb begin
                tail_next[0] = start;
                for (int i = 1; i < TAIL_LEN; i++) begin
                    tail_next[i] = tail[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (act == ACT_CLEAR) begin
                    tail <= '0;
                end else begin
                    tail <= tail_next;
                end
            end

            assign tail_busy = |tail;
        end else begin : g_no_tail
            assign tail_busy = 1'b0;
        end
    endgenerate

    // Output register: READY never comes from combinational logic.
    always_ff @(posedge clk) begin
        if (act == ACT_CLEAR) begin
            ready <= 1'b1;
        end else begin
            ready <= !(start || tail_busy);
        end
    end

endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
    import iowg_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic ale,
    input  logic io_cycle,
    input  logic port_sel,
    input  logic rd_n,
    input  logic wr_n,
    output logic ready
);

    bus_sample_t bus;
    wait_act_e   act;

    always_comb begin
        bus.ale      = ale;
        bus.io_cycle = io_cycle;
        bus.port_sel = port_sel;
        bus.rd_act   = !rd_n;
        bus.wr_act   = !wr_n;
    end

    iowg_access_gate gate_i (
        .clk (clk),
        .bus (bus),
        .act (act)
    );

    iowg_wait_chain #(
        .WAIT_STATES (WAIT_STATES)
    ) chain_i (
        .clk   (clk),
        .act   (act),
        .ready (ready)
    );

endmodule

// File: rtl/iowg_chk.sv
module iowg_chk #(
    parameter int WAIT_STATES = 2
) (
    input logic clk,
    input logic ale,
    input logic io_cycle,
    input logic port_sel,
    input logic rd_n,
    input logic wr_n,
    input logic ready
);

    // The checks start only after the first ale edge; the state before it is undefined.
    logic        armed   = 1'b0;
    logic        waited  = 1'b0;
    logic [15:0] low_run = '0;

    always_ff @(posedge clk) begin
        armed   <= armed | ale;
        waited  <= ale ? 1'b0 : (waited | !ready);
        low_run <= (ale || ready) ? '0 : low_run + 16'd1;
    end

    AST_ALE_CLEARS: assert property (@(posedge clk) disable iff (!armed)
        ale |=> ready); // R1

    AST_FALL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!armed)
        $fell(ready) |-> $past(!ale && io_cycle && port_sel && (!rd_n || !wr_n))); // R2

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!armed)
        !ready |-> (low_run < 16'(WAIT_STATES))); // R3

    AST_WAIT_FULL: assert property (@(posedge clk) disable iff (!armed)
        ($rose(ready) && !$past(ale)) |-> (low_run == 16'(WAIT_STATES))); // R3

    AST_MEM_NO_WAIT: assert property (@(posedge clk) disable iff (!armed)
        (!ale && !io_cycle && ready) |=> ready); // R4

    AST_OTHER_PORT_NO_WAIT: assert property (@(posedge clk) disable iff (!armed)
        (!ale && !port_sel && ready) |=> ready); // R5

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!armed)
        $fell(ready) |-> !$past(waited)); // R6

endmodule

bind io_wait_gen iowg_chk #(.WAIT_STATES(WAIT_STATES)) chk_i (
    .clk      (clk),
    .ale      (ale),
    .io_cycle (io_cycle),
    .port_sel (port_sel),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .ready    (ready)
);

// File: tb/io_wait_gen_tb_top.sv
module io_wait_gen_tb_top;

    localparam int LEN_A = 2;
    localparam int LEN_B = 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic ale = 1'b0, io_cycle = 1'b0, port_sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic ready_a, ready_b;

    io_wait_gen #(.WAIT_STATES(LEN_A)) dut_i (
        .clk(clk), .ale(ale), .io_cycle(io_cycle), .port_sel(port_sel),
        .rd_n(rd_n), .wr_n(wr_n), .ready(ready_a));

    io_wait_gen #(.WAIT_STATES(LEN_B)) dut1_i (
        .clk(clk), .ale(ale), .io_cycle(io_cycle), .port_sel(port_sel),
        .rd_n(rd_n), .wr_n(wr_n), .ready(ready_b));

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    armed = 1'b0;
    bit    done = 1'b0;
    int    rem_a = 0, rem_b = 0;
    bit    used = 1'b0;
    int    lows_a = 0, lows_b = 0;

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string req, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Behavioural reference: countdown plus used-in-this-bus-cycle flag.
    always @(posedge clk) begin
        if (ale) begin
            armed = 1'b1;
            rem_a = 0;
            rem_b = 0;
            used  = 1'b0;
        end else if (io_cycle && port_sel && (!rd_n || !wr_n) && !used) begin
            used  = 1'b1;
            rem_a = LEN_A;
            rem_b = LEN_B;
        end else begin
            if (rem_a > 0) rem_a--;
            if (rem_b > 0) rem_b--;
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            check(ready_a, logic'(rem_a == 0), cur_req, "dut_i per-cycle");
            check(ready_b, logic'(rem_b == 0), {"R9 ", cur_req}, "dut1_i per-cycle");
            if (!ready_a) lows_a++;
            if (!ready_b) lows_b++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic strobe(input bit on, input bit is_wr);
        rd_n = !(on && !is_wr);
        wr_n = !(on && is_wr);
    endtask

    task automatic bus_cycle(input bit io, input bit ps, input bit is_wr, input int hold,
                             input int exp_a, input int exp_b, input string req);
        cur_req  = req;
        lows_a   = 0;
        lows_b   = 0;
        ale      = 1'b1;
        io_cycle = io;
        port_sel = ps;
        step(1);
        ale = 1'b0;
        step(1);
        strobe(1'b1, is_wr);
        step(hold);
        strobe(1'b0, is_wr);
        step(3);
        check_int(lows_a, exp_a, req, "dut_i low cycles");
        check_int(lows_b, exp_b, {"R9 ", req}, "dut1_i low cycles");
    endtask

    initial begin
        step(3);
        // R1: first ale brings both instances to ready
        ale = 1'b1;
        step(1);
        check(ready_a, 1'b1, "R1", "ready after first ale");
        check(ready_b, 1'b1, "R1", "ready after first ale (one-wait)");
        ale = 1'b0;
        step(2);

        bus_cycle(1, 1, 0, 4, LEN_A, LEN_B, "R2 R3 read");
        bus_cycle(1, 1, 1, 4, LEN_A, LEN_B, "R8 write");
        bus_cycle(1, 1, 0, 1, LEN_A, LEN_B, "R3 short strobe");
        bus_cycle(0, 1, 0, 4, 0, 0, "R4 memory read");
        bus_cycle(0, 1, 1, 4, 0, 0, "R4 memory write");
        bus_cycle(1, 0, 0, 4, 0, 0, "R5 other port");
        bus_cycle(1, 1, 0, 8, LEN_A, LEN_B, "R6 long strobe");

        // R6: second strobe pulse in the same bus cycle
        cur_req = "R6 double pulse";
        lows_a = 0; lows_b = 0;
        ale = 1'b1; io_cycle = 1'b1; port_sel = 1'b1;
        step(1);
        ale = 1'b0;
        step(1);
        strobe(1'b1, 1'b0); step(4);
        strobe(1'b0, 1'b0); step(1);
        strobe(1'b1, 1'b1); step(4);
        strobe(1'b0, 1'b1); step(3);
        check_int(lows_a, LEN_A, "R6", "double pulse dut_i");
        check_int(lows_b, LEN_B, "R6", "double pulse dut1_i");

        // R7: ale one cycle into a wait ends it
        cur_req = "R7 abort";
        ale = 1'b1; step(1);
        ale = 1'b0; step(1);
        lows_a = 0; lows_b = 0;
        strobe(1'b1, 1'b0);
        step(1);
        check(ready_a, 1'b0, "R7", "wait started");
        ale = 1'b1;
        step(1);
        check(ready_a, 1'b1, "R7", "ready right after abort ale");
        check(ready_b, 1'b1, "R7", "ready right after abort ale (one-wait)");

        // R1: ale and qualifying strobe at the same edge; clear wins, start follows
        cur_req = "R1 ale with strobe";
        lows_a = 0; lows_b = 0;
        step(1);
        check(ready_a, 1'b1, "R1", "ale plus strobe same edge");
        ale = 1'b0;
        step(1);
        check(ready_a, 1'b0, "R2", "start at next edge without ale");
        strobe(1'b0, 1'b0);
        step(4);
        check_int(lows_a, LEN_A, "R1", "waits after combined edge dut_i");
        check_int(lows_b, LEN_B, "R9", "waits after combined edge dut1_i");

        // back-to-back bus cycles to the port
        bus_cycle(1, 1, 1, 2, LEN_A, LEN_B, "R2 back-to-back A");
        bus_cycle(1, 1, 0, 2, LEN_A, LEN_B, "R2 back-to-back B");
        bus_cycle(0, 0, 0, 3, 0, 0, "R4 fetch");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule